// File: doc/BRIEF.md
# DRAM Command Timing Gate

This block stands between a memory controller's command scheduler and the DRAM command bus of one rank. Each cycle the scheduler offers one command (row open, column read, column write, row close, or refresh) with a bank-group and bank address. The gate answers in the same cycle with `grant`: high only when issuing that command now breaks none of the programmed spacing rules. A granted command is taken as issued on that clock edge. The gate also raises a periodic `refresh_req` that stays up until a refresh is granted.

All spacing values are given in clock cycles on input ports. The gate copies them into a snapshot only while it is idle: every bank closed, and neither a refresh blackout nor a second command-rate cycle in progress. It keeps per-bank down-counters for the open-to-column delay, the open-to-close minimum (extended by reads and write bursts) and the close-to-reopen delay. It also keeps per-group and rank-wide open-spacing counters, and a four-deep record of recent row-open ages. A rank-level state machine has three states. READY: commands may be granted. HOLD: the second bus cycle when the command rate is 2. BLACKOUT: the refresh recovery window. Its transitions are: READY to BLACKOUT on a granted refresh with tRFC above 1; READY to HOLD on any other grant when the command rate is 2, or on a refresh with tRFC of 0 or 1 when the command rate is 2; HOLD to READY after one cycle; BLACKOUT to READY when the recovery count reaches 1. Each bank runs a two-state machine, CLOSED to OPEN on a granted open and OPEN to CLOSED on a granted close.

Top module: `dram_cmd_gate`

## Requirements
- R1: A read or write to bank {bg,bank} is granted only if that bank is open and at least tRCD cycles have passed since its open was granted.
- R2: A close to a bank is granted only if that bank is open and at least tRAS cycles have passed since its open.
- R3: An open to a bank is granted only if that bank is closed and at least tRP cycles have passed since its last close.
- R4: Any two granted opens are at least tRRD_S cycles apart; two granted opens within one bank group are at least tRRD_L cycles apart.
- R5: A fifth open is granted only if at least tFAW cycles have passed since the fourth most recent granted open.
- R6: A close to a bank is granted only if at least tRTP cycles have passed since the last read granted to that bank.
- R7: A close to a bank is granted only if at least tCWL + BL + tWR cycles have passed since the last write granted to that bank, BL being the burst length in clocks.
- R8: `refresh_req` rises tREFI cycles after reset and again every tREFI cycles after that, and falls in the cycle after a refresh is granted (unless a new interval ends in that same cycle).
- R9: A refresh is granted only when every bank is closed with its tRP elapsed; after a refresh granted at cycle t, nothing is granted before cycle t + tRFC.
- R10: With the command rate set to 2, no command is granted in the cycle after any grant.
- R11: `grant` equals `cmd_valid` AND the command being legal, in the same cycle; command codes are 0 open, 1 read, 2 write, 3 close, 4 refresh, and codes 5 to 7 are never granted; after reset all banks are closed and `refresh_req` is low.
- R12: The timing inputs take effect only through a snapshot taken in cycles where the gate is idle; changes made while any bank is open do not affect commands issued before the gate next becomes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the timing snapshot |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_kind | input | 3 | Command code (0 open, 1 read, 2 write, 3 close, 4 refresh) |
| cmd_bg | input | BG_W | Bank group address |
| cmd_bank | input | BA_W | Bank address within the group |
| t_rcd | input | TW | Open to column command delay |
| t_ras | input | TW | Open to close minimum |
| t_rp | input | TW | Close to reopen delay |
| t_rrd_s | input | TW | Open spacing, any groups |
| t_rrd_l | input | TW | Open spacing, same group |
| t_faw | input | TW | Window for four opens |
| t_rtp | input | TW | Read to close minimum |
| t_wr | input | TW | Write burst end to close minimum |
| t_cwl | input | TW | Write command to first data |
| t_bl | input | TW | Burst length in clocks |
| t_rfc | input | RW | Refresh recovery cycles |
| t_refi | input | RW | Refresh interval cycles |
| cmd_rate2 | input | 1 | Command rate 2 (each command holds the bus two cycles) |
| grant | output | 1 | The offered command is issued this cycle |
| refresh_req | output | 1 | A refresh is due |

## Verification
The bench builds the gate with two bank groups of four banks, 6-bit spacing fields and 10-bit refresh fields. Eight banks keep the reference model small but still let opens to alternating groups run into the four-open window before tRRD limits interfere. Two groups let the same-group and any-group open spacings be told apart. A refresh interval of 300 cycles lets several refresh requests and refresh blackouts occur inside a few thousand cycles of mixed traffic. The model is checked with the command rate at 1 and at 2, and with a spacing input changed while a bank is open.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_REF = 3'd4
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_HOLD     = 2'd1,
        ST_BLACKOUT = 2'd2
    } gate_state_e;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_state_e;

endpackage

// File: rtl/dcg_bank.sv
module dcg_bank
    import dcg_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic          pre_go,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_ras,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_rtp,
    input  logic [TW-1:0] t_wr,
    input  logic [TW-1:0] t_cwl,
    input  logic [TW-1:0] t_bl,
    output logic          is_open,
    output logic          rw_ok,
    output logic          pre_ok,
    output logic          act_ok
);
    localparam int PW = TW + 2;

    bank_state_e   st, st_nx;
    logic [TW-1:0] rcd_cnt;
    logic [TW-1:0] rp_cnt;
    logic [PW-1:0] pre_cnt;

    logic [PW-1:0] wr_need;
    logic [PW-1:0] pre_dec;
    logic [PW-1:0] ras_ld, rtp_ld, wr_ld, pre_nx;

    assign wr_need = PW'(t_cwl) + PW'(t_bl) + PW'(t_wr);
    assign pre_dec = (pre_cnt == '0) ? '0 : pre_cnt - 1'b1;
    assign ras_ld  = (t_ras == '0) ? '0 : PW'(t_ras) - 1'b1;
    assign rtp_ld  = (t_rtp == '0) ? '0 : PW'(t_rtp) - 1'b1;
    assign wr_ld   = (wr_need == '0) ? '0 : wr_need - 1'b1;

    // Close window: the latest of all pending limits wins.
    always_comb begin
        pre_nx = pre_dec;
        if (act_go && ras_ld > pre_nx) pre_nx = ras_ld;
        if (rd_go  && rtp_ld > pre_nx) pre_nx = rtp_ld;
        if (wr_go  && wr_ld  > pre_nx) pre_nx = wr_ld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            rp_cnt  <= '0;
            pre_cnt <= '0;
        end else begin
            if (act_go)
                rcd_cnt <= (t_rcd == '0) ? '0 : t_rcd - 1'b1;
            else if (rcd_cnt != '0)
                rcd_cnt <= rcd_cnt - 1'b1;
            if (pre_go)
                rp_cnt <= (t_rp == '0) ? '0 : t_rp - 1'b1;
            else if (rp_cnt != '0)
                rp_cnt <= rp_cnt - 1'b1;
            pre_cnt <= pre_nx;
        end
    end

    // Bank state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BK_CLOSED;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            BK_CLOSED: if (act_go) st_nx = BK_OPEN;
            BK_OPEN:   if (pre_go) st_nx = BK_CLOSED;
            default:   st_nx = BK_CLOSED;
        endcase
    end

    // Outputs
    always_comb begin
        is_open = (st == BK_OPEN);
        rw_ok   = (st == BK_OPEN)   && (rcd_cnt == '0);
        pre_ok  = (st == BK_OPEN)   && (pre_cnt == '0);
        act_ok  = (st == BK_CLOSED) && (rp_cnt == '0);
    end

    assert_col_after_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go || wr_go) |-> (st == BK_OPEN && rcd_cnt == '0));

    assert_close_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |-> (st == BK_OPEN && pre_cnt == '0));

    assert_open_after_rp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (st == BK_CLOSED && rp_cnt == '0));

    assert_write_holds_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ((pre_cnt + 1'b1) >= $past(wr_need)));

endmodule

// File: rtl/dcg_act_window.sv
module dcg_act_window #(
    parameter int GW    = 2,
    parameter int TW    = 8,
    parameter int FAW_N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_go,
    input  logic [GW-1:0]        act_grp,
    input  logic [TW-1:0]        t_rrd_s,
    input  logic [TW-1:0]        t_rrd_l,
    input  logic [TW-1:0]        t_faw,
    output logic [(1<<GW)-1:0]   grp_ok,
    output logic                 spacing_ok
);
    localparam int NG = 1 << GW;

    logic [TW-1:0] rrds_cnt;
    logic [TW-1:0] grp_cnt [NG];
    logic [TW-1:0] age     [FAW_N];

    always_ff @(posedge clk) begin
        if (!rst_n)
            rrds_cnt <= '0;
        else if (act_go)
            rrds_cnt <= (t_rrd_s == '0) ? '0 : t_rrd_s - 1'b1;
        else if (rrds_cnt != '0)
            rrds_cnt <= rrds_cnt - 1'b1;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_cnt[g] <= '0;
            else if (act_go && act_grp == GW'(g))
                grp_cnt[g] <= (t_rrd_l == '0) ? '0 : t_rrd_l - 1'b1;
            else if (grp_cnt[g] != '0)
                grp_cnt[g] <= grp_cnt[g] - 1'b1;
        end
        assign grp_ok[g] = (grp_cnt[g] == '0);
    end

    // Shift record of remaining window time for the last FAW_N opens.
    for (genvar i = 0; i < FAW_N; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age[i] <= '0;
            end else if (act_go) begin
                if (i == 0)
                    age[i] <= (t_faw == '0) ? '0 : t_faw - 1'b1;
                else
                    age[i] <= (age[i-1] == '0) ? '0 : age[i-1] - 1'b1;
            end else if (age[i] != '0) begin
                age[i] <= age[i] - 1'b1;
            end
        end
    end

    assign spacing_ok = (rrds_cnt == '0) && (age[FAW_N-1] == '0);

    assert_open_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (rrds_cnt == '0 && grp_cnt[act_grp] == '0));

    assert_four_open_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (age[FAW_N-1] == '0));

endmodule

// File: rtl/dcg_refresh_timer.sv
module dcg_refresh_timer #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] t_refi,
    input  logic          ref_go,
    output logic          refresh_req
);
    logic [RW-1:0] tmr;
    logic          pend;
    logic          wrap;

    assign wrap = ({1'b0, tmr} + 1'b1) >= {1'b0, t_refi};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr  <= '0;
            pend <= 1'b0;
        end else begin
            tmr <= wrap ? '0 : tmr + 1'b1;
            if (wrap)        pend <= 1'b1;
            else if (ref_go) pend <= 1'b0;
        end
    end

    assign refresh_req = pend;

    assert_req_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_go && !wrap) |=> !refresh_req);

    assert_req_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> refresh_req);

endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
    import dcg_pkg::*;
#(
    parameter int BG_W = 2,
    parameter int BA_W = 2,
    parameter int TW   = 8,
    parameter int RW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_kind,
    input  logic [BG_W-1:0] cmd_bg,
    input  logic [BA_W-1:0] cmd_bank,
    input  logic [TW-1:0]   t_rcd,
    input  logic [TW-1:0]   t_ras,
    input  logic [TW-1:0]   t_rp,
    input  logic [TW-1:0]   t_rrd_s,
    input  logic [TW-1:0]   t_rrd_l,
    input  logic [TW-1:0]   t_faw,
    input  logic [TW-1:0]   t_rtp,
    input  logic [TW-1:0]   t_wr,
    input  logic [TW-1:0]   t_cwl,
    input  logic [TW-1:0]   t_bl,
    input  logic [RW-1:0]   t_rfc,
    input  logic [RW-1:0]   t_refi,
    input  logic            cmd_rate2,
    output logic            grant,
    output logic            refresh_req
);
    localparam int IW = BG_W + BA_W;
    localparam int NB = 1 << IW;
    localparam int NG = 1 << BG_W;

    // Timing snapshot
    logic [TW-1:0] s_rcd, s_ras, s_rp, s_rrd_s, s_rrd_l, s_faw;
    logic [TW-1:0] s_rtp, s_wr, s_cwl, s_bl;
    logic [RW-1:0] s_rfc, s_refi;
    logic          s_rate2;

    gate_state_e   st, st_nx;
    logic [RW-1:0] rfc_cnt;
    logic          legal;
    logic          idle;
    logic [IW-1:0] idx;

    logic [NB-1:0] bk_open, bk_rw_ok, bk_pre_ok, bk_act_ok;
    logic [NG-1:0] win_grp_ok;
    logic          win_ok;
    logic          go_act, go_rd, go_wr, go_pre, go_ref;

    assign idx  = {cmd_bg, cmd_bank};
    assign idle = (st == ST_READY) && !(|bk_open);

    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            s_rcd   <= t_rcd;
            s_ras   <= t_ras;
            s_rp    <= t_rp;
            s_rrd_s <= t_rrd_s;
            s_rrd_l <= t_rrd_l;
            s_faw   <= t_faw;
            s_rtp   <= t_rtp;
            s_wr    <= t_wr;
            s_cwl   <= t_cwl;
            s_bl    <= t_bl;
            s_rfc   <= t_rfc;
            s_refi  <= t_refi;
            s_rate2 <= cmd_rate2;
        end
    end

    // Output process: legality and grant
    always_comb begin
        legal = 1'b0;
        case (cmd_kind)
            CMD_ACT:        legal = bk_act_ok[idx] && win_ok && win_grp_ok[cmd_bg];
            CMD_RD, CMD_WR: legal = bk_rw_ok[idx];
            CMD_PRE:        legal = bk_pre_ok[idx];
            CMD_REF:        legal = &bk_act_ok;
            default:        legal = 1'b0;
        endcase
        grant  = cmd_valid && (st == ST_READY) && legal;
        go_act = grant && (cmd_kind == CMD_ACT);
        go_rd  = grant && (cmd_kind == CMD_RD);
        go_wr  = grant && (cmd_kind == CMD_WR);
        go_pre = grant && (cmd_kind == CMD_PRE);
        go_ref = grant && (cmd_kind == CMD_REF);
    end

    // Rank state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_READY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_READY: begin
                if (go_ref && s_rfc > RW'(1)) st_nx = ST_BLACKOUT;
                else if (grant && s_rate2)    st_nx = ST_HOLD;
            end
            ST_HOLD:     st_nx = ST_READY;
            ST_BLACKOUT: if (rfc_cnt <= RW'(1)) st_nx = ST_READY;
            default:     st_nx = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rfc_cnt <= '0;
        else if (go_ref)
            rfc_cnt <= (s_rfc == '0) ? '0 : s_rfc - 1'b1;
        else if (rfc_cnt != '0)
            rfc_cnt <= rfc_cnt - 1'b1;
    end

    for (genvar i = 0; i < NB; i++) begin : g_bank
        dcg_bank #(.TW(TW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (go_act && idx == IW'(i)),
            .rd_go   (go_rd  && idx == IW'(i)),
            .wr_go   (go_wr  && idx == IW'(i)),
            .pre_go  (go_pre && idx == IW'(i)),
            .t_rcd   (s_rcd),
            .t_ras   (s_ras),
            .t_rp    (s_rp),
            .t_rtp   (s_rtp),
            .t_wr    (s_wr),
            .t_cwl   (s_cwl),
            .t_bl    (s_bl),
            .is_open (bk_open[i]),
            .rw_ok   (bk_rw_ok[i]),
            .pre_ok  (bk_pre_ok[i]),
            .act_ok  (bk_act_ok[i])
        );
    end

    dcg_act_window #(.GW(BG_W), .TW(TW), .FAW_N(4)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_go     (go_act),
        .act_grp    (cmd_bg),
        .t_rrd_s    (s_rrd_s),
        .t_rrd_l    (s_rrd_l),
        .t_faw      (s_faw),
        .grp_ok     (win_grp_ok),
        .spacing_ok (win_ok)
    );

    dcg_refresh_timer #(.RW(RW)) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .t_refi      (s_refi),
        .ref_go      (go_ref),
        .refresh_req (refresh_req)
    );

    assert_ref_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go_ref |-> (!(|bk_open) && (&bk_act_ok)));

    assert_ref_blackout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ref && s_rfc > RW'(1)) |=> !grant);

    assert_rate2_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && s_rate2) |=> !grant);

    assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind > 3'd4) |-> !grant);

    assert_snapshot_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|bk_open) |=> ($stable(s_rcd) && $stable(s_rate2) && $stable(s_faw)));

endmodule

// File: tb/dram_cmd_gate_test.sv
module dram_cmd_gate_test;
    import dcg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BG_W = 1;
    localparam int BA_W = 2;
    localparam int TW   = 6;
    localparam int RW   = 10;
    localparam int NB   = 1 << (BG_W + BA_W);
    localparam int NG   = 1 << BG_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_kind = 3'd0;
    logic [BG_W-1:0] cmd_bg = '0;
    logic [BA_W-1:0] cmd_bank = '0;
    logic [TW-1:0]   t_rcd = 6'd4, t_ras = 6'd9, t_rp = 6'd3, t_rrd_s = 6'd2;
    logic [TW-1:0]   t_rrd_l = 6'd4, t_faw = 6'd14, t_rtp = 6'd3, t_wr = 6'd5;
    logic [TW-1:0]   t_cwl = 6'd3, t_bl = 6'd4;
    logic [RW-1:0]   t_rfc = 10'd20, t_refi = 10'd300;
    logic            cmd_rate2 = 1'b0;
    logic            grant, refresh_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cmd_gate #(.BG_W(BG_W), .BA_W(BA_W), .TW(TW), .RW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bg(cmd_bg), .cmd_bank(cmd_bank),
        .t_rcd(t_rcd), .t_ras(t_ras), .t_rp(t_rp), .t_rrd_s(t_rrd_s),
        .t_rrd_l(t_rrd_l), .t_faw(t_faw), .t_rtp(t_rtp), .t_wr(t_wr),
        .t_cwl(t_cwl), .t_bl(t_bl), .t_rfc(t_rfc), .t_refi(t_refi),
        .cmd_rate2(cmd_rate2), .grant(grant), .refresh_req(refresh_req)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int cyc = 0;
    int s_rcd, s_ras, s_rp, s_rrds, s_rrdl, s_faw, s_rtp, s_wr, s_cwl, s_bl, s_rfc, s_refi;
    bit s_r2;
    bit    m_open   [NB];
    int    m_act_at [NB];
    int    m_rw_at  [NB];
    int    m_pre_at [NB];
    string m_pre_tag[NB];
    int    m_grp_at [NG];
    int    m_rrd_at;
    int    faw_q[$];
    int    m_busy_until;
    string m_busy_tag;
    int    m_tmr;
    bit    m_pend;

    task automatic snap_load();
        s_rcd = int'(t_rcd); s_ras = int'(t_ras); s_rp = int'(t_rp);
        s_rrds = int'(t_rrd_s); s_rrdl = int'(t_rrd_l); s_faw = int'(t_faw);
        s_rtp = int'(t_rtp); s_wr = int'(t_wr); s_cwl = int'(t_cwl); s_bl = int'(t_bl);
        s_rfc = int'(t_rfc); s_refi = int'(t_refi); s_r2 = cmd_rate2;
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_act_at[b] = 0; m_rw_at[b] = 0; m_pre_at[b] = 0;
            m_pre_tag[b] = "R2";
        end
        for (int g = 0; g < NG; g++) m_grp_at[g] = 0;
        m_rrd_at = 0; faw_q.delete(); m_busy_until = 0; m_busy_tag = "R10";
        m_tmr = 0; m_pend = 0;
        snap_load();
    endtask

    task automatic model_step();
        int  c, b, g;
        bit  allow, any_open, all_rp, idle, exp_g, wrap;
        string tag;
        c = cyc;
        b = int'({cmd_bg, cmd_bank});
        g = int'(cmd_bg);
        any_open = 0; all_rp = 1;
        for (int i = 0; i < NB; i++) begin
            if (m_open[i]) any_open = 1;
            if (m_open[i] || c < m_act_at[i]) all_rp = 0;
        end
        idle = (c >= m_busy_until) && !any_open;

        chk(refresh_req === m_pend, "R8 refresh_req", int'(refresh_req), int'(m_pend));

        allow = 0; tag = "R11";
        if (c < m_busy_until) begin
            tag = m_busy_tag;
        end else begin
            case (cmd_kind)
                3'd0: begin
                    tag = "R3";
                    if (m_open[b] || c < m_act_at[b]) allow = 0;
                    else if (c < m_grp_at[g] || c < m_rrd_at) begin allow = 0; tag = "R4"; end
                    else if (faw_q.size() >= 4 && c - faw_q[0] < s_faw) begin allow = 0; tag = "R5"; end
                    else allow = 1;
                end
                3'd1, 3'd2: begin tag = "R1"; allow = m_open[b] && c >= m_rw_at[b]; end
                3'd3: begin
                    tag = "R2";
                    if (!m_open[b]) allow = 0;
                    else begin allow = (c >= m_pre_at[b]); tag = m_pre_tag[b]; end
                end
                3'd4: begin tag = "R9"; allow = all_rp; end
                default: begin tag = "R11"; allow = 0; end
            endcase
        end
        exp_g = cmd_valid && allow;
        if (!cmd_valid) tag = "R11";
        chk(grant === exp_g, {tag, " grant"}, int'(grant), int'(exp_g));

        if (exp_g) begin
            case (cmd_kind)
                3'd0: begin
                    m_open[b] = 1; m_rw_at[b] = c + s_rcd;
                    if (c + s_ras >= m_pre_at[b]) begin m_pre_at[b] = c + s_ras; m_pre_tag[b] = "R2"; end
                    m_grp_at[g] = c + s_rrdl; m_rrd_at = c + s_rrds;
                    faw_q.push_back(c);
                    if (faw_q.size() > 4) void'(faw_q.pop_front());
                end
                3'd1: if (c + s_rtp >= m_pre_at[b]) begin m_pre_at[b] = c + s_rtp; m_pre_tag[b] = "R6"; end
                3'd2: if (c + s_cwl + s_bl + s_wr >= m_pre_at[b]) begin
                          m_pre_at[b] = c + s_cwl + s_bl + s_wr; m_pre_tag[b] = "R7";
                      end
                3'd3: begin m_open[b] = 0; m_act_at[b] = c + s_rp; end
                default: ;
            endcase
            if (cmd_kind == 3'd4) begin
                if (s_rfc > 1) begin m_busy_until = c + s_rfc; m_busy_tag = "R9"; end
                else if (s_r2) begin m_busy_until = c + 2; m_busy_tag = "R10"; end
            end else if (s_r2) begin
                m_busy_until = c + 2; m_busy_tag = "R10";
            end
        end

        wrap = (m_tmr + 1 >= s_refi);
        m_tmr = wrap ? 0 : m_tmr + 1;
        if (wrap) m_pend = 1;
        else if (exp_g && cmd_kind == 3'd4) m_pend = 0;

        if (idle) snap_load();
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst_n) model_reset();
        else if (!done) model_step();
        cyc++;
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic [2:0] k, input int g, input int b);
        cmd_valid = 1'b1; cmd_kind = k; cmd_bg = BG_W'(g); cmd_bank = BA_W'(b);
    endtask

    task automatic issue(input logic [2:0] k, input int g, input int b, output int waited);
        waited = 0;
        @(negedge clk);
        drive(k, g, b);
        forever begin
            #2; waited++;
            if (grant === 1'b1) break;
            if (waited >= 400) begin
                chk(0, "R11 issue never granted", waited, 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic hold_cmd(input logic [2:0] k, input int g, input int b, input int n);
        repeat (n) begin @(negedge clk); drive(k, g, b); end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) begin @(negedge clk); cmd_valid = 1'b0; end
    endtask

    task automatic close_all();
        int w;
        for (int b = 0; b < NB; b++)
            if (m_open[b]) issue(3'(CMD_PRE), b >> BA_W, b & ((1 << BA_W) - 1), w);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "R11 watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state, nothing open, unknown codes refused
        hold_cmd(3'(CMD_RD), 0, 0, 2);
        hold_cmd(3'd6, 1, 1, 2);
        #2 chk(grant === 1'b0, "R11 code 6 refused", int'(grant), 0);
        chk(refresh_req === 1'b0, "R11 refresh_req after reset", int'(refresh_req), 0);

        // R1: read waits tRCD after open
        issue(3'(CMD_ACT), 0, 0, w);
        issue(3'(CMD_RD), 0, 0, w);
        chk(w == 4, "R1 read wait", w, 4);
        // R4 and R5: opens across groups run into the window
        issue(3'(CMD_ACT), 0, 1, w);
        issue(3'(CMD_ACT), 1, 0, w);
        issue(3'(CMD_ACT), 1, 1, w);
        issue(3'(CMD_ACT), 0, 2, w);
        issue(3'(CMD_ACT), 1, 2, w);
        // R7, R6, R2
        issue(3'(CMD_WR), 1, 0, w);
        issue(3'(CMD_PRE), 1, 0, w);
        issue(3'(CMD_RD), 0, 1, w);
        issue(3'(CMD_PRE), 0, 1, w);
        issue(3'(CMD_ACT), 0, 1, w);
        issue(3'(CMD_PRE), 0, 1, w);
        // R3: reopen after close
        issue(3'(CMD_ACT), 0, 1, w);
        // R9: refresh refused while open
        hold_cmd(3'(CMD_REF), 0, 0, 6);
        close_all();
        issue(3'(CMD_REF), 0, 0, w);
        hold_cmd(3'(CMD_ACT), 0, 3, 25);
        idle_cycles(2);

        // R12: spacing input changed while a bank is open
        issue(3'(CMD_ACT), 1, 3, w);
        @(negedge clk); cmd_valid = 1'b0; t_rcd = 6'd10;
        issue(3'(CMD_RD), 1, 3, w);
        chk(w == 3, "R12 old tRCD kept while open", w, 3);
        close_all();
        idle_cycles(3);
        issue(3'(CMD_ACT), 1, 3, w);
        issue(3'(CMD_RD), 1, 3, w);
        chk(w == 10, "R12 new tRCD after idle", w, 10);
        close_all();

        // R10: command rate 2
        idle_cycles(12);
        cmd_rate2 = 1'b1; t_rcd = 6'd2;
        idle_cycles(3);
        hold_cmd(3'(CMD_ACT), 0, 0, 1);
        hold_cmd(3'(CMD_ACT), 1, 0, 4);
        hold_cmd(3'(CMD_RD), 0, 0, 6);
        close_all();

        // Mixed traffic, rate 2 then rate 1
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (i == 3000) cmd_rate2 = 1'b0;
            cmd_valid = ($urandom % 4) != 0;
            cmd_kind  = 3'($urandom % 7);
            cmd_bg    = BG_W'($urandom);
            cmd_bank  = BA_W'($urandom);
        end
        idle_cycles(4);
        done = 1;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule